// File: doc/BRIEF.md
# Bit-Serial NOR-Only Arithmetic/Logic Unit

This unit performs 8-bit AND, OR, XOR, add-with-carry and subtract-with-carry. Its only computing element is one two-input NOR. Every result bit, including the sum and carry of the full adder, comes from a short fixed sequence of NOR evaluations. Small scratch latches hold the intermediate values between evaluations, and a step counter drives the sequence. The operands are walked one bit position at a time, least significant bit first, so the carry latch passes from one bit position to the next without any extra logic.

A controller presents the accumulator byte, the operand byte, an operation code and the current flag bit, then pulses start. The unit copies all of these into its own registers. It ignores its inputs until the operation finishes, and then raises done for one cycle. The result byte and the flag output stay unchanged after that until the next operation is accepted. Arithmetic therefore costs tens of cycles, but the hardware is a single gate plus a few flip-flops.

Top module: `nor_serial_alu`

## Requirements
- R1: The operation code selects the function: 0 AND, 1 OR, 2 XOR, 3 ADD, 4 SUB. For codes 0 to 2 the result is the bitwise function of acc and opnd.
- R2: For ADD, result is the low 8 bits of acc + opnd + flag_in, and flag_out is the carry out of bit 7.
- R3: For SUB, result is the low 8 bits of acc + ~opnd + flag_in, and flag_out is the carry out of bit 7. A flag of 1 means no borrow.
- R4: For AND, OR and XOR, flag_out equals the flag_in value sampled at the accepted start.
- R5: done rises exactly 8*k cycles after the clock edge that accepts start, where k is 3 for AND, 2 for OR, 5 for XOR, 9 for ADD and 10 for SUB. done is high for one cycle only.
- R6: From done until the next accepted start, result and flag_out do not change, whatever the data inputs do.
- R7: A start pulse that arrives while an operation is running is ignored. The running operation completes with its original operands and its original timing.
- R8: A start with an operation code of 5, 6 or 7 is ignored. No done follows, and result and flag_out keep their values.
- R9: After reset, result is 0, flag_out is 0, done is 0 and the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation; sampled while idle |
| op | input | 3 | Operation code (0 AND, 1 OR, 2 XOR, 3 ADD, 4 SUB) |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| flag_in | input | 1 | Carry-in, taken from the CPU flag |
| result | output | 8 | Result byte |
| flag_out | output | 1 | Carry-out for ADD and SUB; otherwise the carry-in passed through |
| done | output | 1 | One-cycle pulse when the result is complete |

## Verification
A wrong step sequence or a scratch latch that holds the wrong value corrupts a result bit. That error shows on result and flag_out when done rises, one full operation after start. Vectors chosen to make the carry ripple through every bit position expose an error at any bit. An error in the bit or step counter moves the done pulse away from its fixed multiple of eight cycles, so the latency check sees it at the first operation. A start that is wrongly accepted while the unit is busy, or an invalid code that is wrongly accepted, shows up as an altered result, a shifted done, or a done that should not appear.

// File: rtl/nor_serial_alu.sv
module nor_serial_alu #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] opnd,
  input  logic             flag_in,
  output logic [WIDTH-1:0] result,
  output logic             flag_out,
  output logic             done
);
  localparam int BITW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [BITW-1:0] LAST_BIT = BITW'(WIDTH - 1);

  localparam logic [2:0] OP_AND = 3'd0, OP_OR = 3'd1, OP_XOR = 3'd2,
                         OP_ADD = 3'd3, OP_SUB = 3'd4;

  localparam logic [2:0] SRC_A = 3'd0, SRC_B = 3'd1, SRC_C = 3'd2,
                         SRC_T0 = 3'd3, SRC_T1 = 3'd4, SRC_T2 = 3'd5, SRC_T3 = 3'd6;
  localparam logic [2:0] DST_T0 = 3'd0, DST_T1 = 3'd1, DST_T2 = 3'd2,
                         DST_T3 = 3'd3, DST_R = 3'd4, DST_C = 3'd5;

  logic             busy;
  logic [2:0]       op_q;
  logic [WIDTH-1:0] a_sh, b_sh, res;
  logic             carry;
  logic [3:0]       tmp;
  logic [BITW-1:0]  bitc;
  logic [3:0]       step, k;
  logic [2:0]       sx, sy, dst, bsrc;
  logic             last, xv, yv, nor_out;

  wire op_ok = (op <= OP_SUB);

  assign result   = res;
  assign flag_out = carry;

  // microcode: which two latches feed the NOR and where its output goes
  always_comb begin
    sx = SRC_A; sy = SRC_A; dst = DST_T0; last = 1'b0;
    bsrc = (op_q == OP_SUB) ? SRC_T3 : SRC_B;
    k    = (op_q == OP_SUB) ? step - 4'd1 : step;
    case (op_q)
      OP_OR: case (step)
        4'd0:    begin sx = SRC_A;  sy = SRC_B;  dst = DST_T0; end
        default: begin sx = SRC_T0; sy = SRC_T0; dst = DST_R; last = 1'b1; end
      endcase
      OP_AND: case (step)
        4'd0:    begin sx = SRC_A;  sy = SRC_A;  dst = DST_T0; end
        4'd1:    begin sx = SRC_B;  sy = SRC_B;  dst = DST_T1; end
        default: begin sx = SRC_T0; sy = SRC_T1; dst = DST_R; last = 1'b1; end
      endcase
      OP_XOR: case (step)
        4'd0:    begin sx = SRC_A;  sy = SRC_B;  dst = DST_T0; end
        4'd1:    begin sx = SRC_A;  sy = SRC_T0; dst = DST_T1; end
        4'd2:    begin sx = SRC_B;  sy = SRC_T0; dst = DST_T2; end
        4'd3:    begin sx = SRC_T1; sy = SRC_T2; dst = DST_T3; end
        default: begin sx = SRC_T3; sy = SRC_T3; dst = DST_R; last = 1'b1; end
      endcase
      default: if (op_q == OP_SUB && step == 4'd0) begin
        sx = SRC_B; sy = SRC_B; dst = DST_T3;
      end else begin
        case (k)
          4'd0:    begin sx = SRC_A;  sy = bsrc;   dst = DST_T0; end
          4'd1:    begin sx = SRC_A;  sy = SRC_T0; dst = DST_T1; end
          4'd2:    begin sx = bsrc;   sy = SRC_T0; dst = DST_T2; end
          4'd3:    begin sx = SRC_T1; sy = SRC_T2; dst = DST_T3; end
          4'd4:    begin sx = SRC_T3; sy = SRC_C;  dst = DST_T1; end
          4'd5:    begin sx = SRC_T3; sy = SRC_T1; dst = DST_T2; end
          4'd6:    begin sx = SRC_C;  sy = SRC_T1; dst = DST_T3; end
          4'd7:    begin sx = SRC_T2; sy = SRC_T3; dst = DST_R;  end
          default: begin sx = SRC_T0; sy = SRC_T1; dst = DST_C; last = 1'b1; end
        endcase
      end
    endcase
  end

  function automatic logic pick(input logic [2:0] s, input logic a, input logic b,
                                input logic c, input logic [3:0] t);
    case (s)
      SRC_A:   return a;
      SRC_B:   return b;
      SRC_C:   return c;
      SRC_T0:  return t[0];
      SRC_T1:  return t[1];
      SRC_T2:  return t[2];
      default: return t[3];
    endcase
  endfunction

  assign xv      = pick(sx, a_sh[0], b_sh[0], carry, tmp);
  assign yv      = pick(sy, a_sh[0], b_sh[0], carry, tmp);
  assign nor_out = ~(xv | yv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; op_q <= OP_AND;
      a_sh <= '0; b_sh <= '0; res <= '0; carry <= 1'b0;
      tmp <= '0; bitc <= '0; step <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && op_ok) begin
          busy <= 1'b1; op_q <= op; a_sh <= acc; b_sh <= opnd;
          carry <= flag_in; bitc <= '0; step <= '0;
        end
      end else begin
        case (dst)
          DST_T0:  tmp[0] <= nor_out;
          DST_T1:  tmp[1] <= nor_out;
          DST_T2:  tmp[2] <= nor_out;
          DST_T3:  tmp[3] <= nor_out;
          DST_R:   res <= {nor_out, res[WIDTH-1:1]};
          default: carry <= nor_out;
        endcase
        if (last) begin
          step <= '0;
          a_sh <= a_sh >> 1;
          b_sh <= b_sh >> 1;
          bitc <= bitc + 1'b1;
          if (bitc == LAST_BIT) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          step <= step + 4'd1;
        end
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && op_ok)) |=> ($stable(result) && $stable(flag_out)));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));
  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !op_ok) |=> (!busy && !done));
endmodule

// File: tb/nor_serial_alu_test.sv
`timescale 1ns/1ps
module nor_serial_alu_test;
  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, flag_in = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] acc = 8'h00, opnd = 8'h00;
  logic [7:0] result;
  logic       flag_out, done;
  int checks = 0, errors = 0;

  nor_serial_alu uut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc(acc),
    .opnd(opnd), .flag_in(flag_in), .result(result), .flag_out(flag_out), .done(done));

  always #4 clk = ~clk;

  // {op, acc, opnd, flag_in, expected result, expected flag}
  localparam logic [28:0] VEC [13] = '{
    {3'd0, 8'hF0, 8'h3C, 1'b0, 8'h30, 1'b0},
    {3'd1, 8'hF0, 8'h3C, 1'b1, 8'hFC, 1'b1},
    {3'd2, 8'hF0, 8'h3C, 1'b0, 8'hCC, 1'b0},
    {3'd3, 8'h19, 8'h5B, 1'b0, 8'h74, 1'b0},
    {3'd3, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
    {3'd3, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1},
    {3'd3, 8'h80, 8'h80, 1'b1, 8'h01, 1'b1},
    {3'd4, 8'h50, 8'h20, 1'b1, 8'h30, 1'b1},
    {3'd4, 8'h20, 8'h50, 1'b1, 8'hD0, 1'b0},
    {3'd4, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0},
    {3'd2, 8'hAA, 8'hFF, 1'b1, 8'h55, 1'b1},
    {3'd0, 8'hA5, 8'hFF, 1'b1, 8'hA5, 1'b1},
    {3'd3, 8'h55, 8'hAA, 1'b1, 8'h00, 1'b1}
  };

  function automatic int lat(input logic [2:0] o);
    case (o)
      3'd0: return 24;
      3'd1: return 16;
      3'd2: return 40;
      3'd3: return 72;
      default: return 80;
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] o);
    case (o)
      3'd3: return "R2";
      3'd4: return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic c);
    @(negedge clk);
    op = o; acc = a; opnd = b; flag_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // counts cycles after the accepting edge; optional junk start at cycle inj
  task automatic wait_done(input int inj, output int n);
    n = 0;
    while (!done && n < 200) begin
      if (n == inj) begin
        start = 1'b1; op = 3'd4; acc = 8'hFF; opnd = 8'h00; flag_in = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] hold_r;
    logic hold_f;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result", int'(result), 0);
    check("R9 flag", int'(flag_out), 0);
    check("R9 done", int'(done), 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      logic [28:0] v;
      v = VEC[i];
      launch(v[28:26], v[25:18], v[17:10], v[9]);
      wait_done(-1, n);
      check({rtag(v[28:26]), " result"}, int'(result), int'(v[8:1]));
      check((v[28:26] <= 3'd2) ? "R4 flag" : {rtag(v[28:26]), " flag"},
            int'(flag_out), int'(v[0]));
      check("R5 latency", n, lat(v[28:26]));
      @(negedge clk);
      check("R5 single-cycle done", int'(done), 0);
    end

    // R6: outputs hold after done while inputs move
    launch(3'd3, 8'h3C, 8'h0F, 1'b1);
    wait_done(-1, n);
    hold_r = result; hold_f = flag_out;
    check("R2 result 3C+0F+1", int'(result), 8'h4C);
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      acc = 8'(j * 13); opnd = 8'(j * 7); flag_in = j[0]; op = 3'(j % 5);
    end
    check("R6 result hold", int'(result), int'(hold_r));
    check("R6 flag hold", int'(flag_out), int'(hold_f));

    // R7: start while busy is ignored
    launch(3'd3, 8'h0F, 8'h01, 1'b0);
    wait_done(10, n);
    check("R7 result", int'(result), 8'h10);
    check("R7 flag", int'(flag_out), 0);
    check("R7 latency", n, 72);

    // R8: invalid opcode start is ignored
    for (int c = 5; c < 8; c++) begin
      launch(3'(c), 8'hFF, 8'hFF, 1'b1);
      wait_done(-1, n);
      check("R8 no done", n, 200);
      check("R8 result hold", int'(result), 8'h10);
      check("R8 flag hold", int'(flag_out), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule